// File: doc/BRIEF.md
# Two-Way Mailbox Register Bridge

This block carries single command words between two ports that run on separate clocks, beside a data queue rather than through it. Port A deposits a word into the first mailbox, which port B picks up; port B deposits a word into the second mailbox, which port A picks up. Each mailbox has an active-low full flag. The flag drops when a word is written and rises again when the opposite port reads that word with its mailbox select raised.

Every port operation is qualified by a select, an enable and a write/read direction. A mailbox that holds an unread word refuses further writes. Reading a mailbox does not change the word it holds. Each full flag is set in one clock domain and cleared in the other. The set and clear events are carried across as toggles through a synchronizer chain, so each flag can be seen from both sides. Each port's output bus shows either its queue output word or the mailbox that port reads, depending on its mailbox select.

Top module: `mbox_bridge`

## Requirements
- R1: A port performs an operation only on a rising edge of its clock where its select and its enable are both 1. The write/read input chooses the direction: 1 means write, 0 means read. Without select and enable, nothing changes.
- R2: A port A write with a_mbx = 1, accepted while mailbox 1 is empty, stores a_din in mailbox 1. Port B can then see that word on b_dout while b_mbx = 1.
- R3: A port B write with b_mbx = 1, accepted while mailbox 2 is empty, stores b_din in mailbox 2. Port A can then see that word on a_dout while a_mbx = 1.
- R4: An accepted mailbox write drives the writer-side flag low on the same clock edge. The reader-side flag goes low within SYNC+1 reader clock edges.
- R5: A mailbox write made while the writer-side flag is low is ignored, and the stored word stays as it was.
- R6: A mailbox read (mbx = 1, read direction) made while the reader-side flag is low returns the reader-side flag high on that edge. The writer-side flag returns high within SYNC+1 writer clock edges. A read of an empty mailbox changes nothing.
- R7: A port's output equals its queue input (a_fifo_q or b_fifo_q) while its mbx is 0, and equals the mailbox it reads while its mbx is 1.
- R8: A mailbox keeps its word after it is read. Its contents change only when a write is accepted.
- R9: While rst_n is 0, all four flags read 1 and both mailboxes hold zero.
- R10: A reader-side flag is never low while the matching writer-side flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_clk | input | 1 | Port A clock |
| a_sel | input | 1 | Port A select |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | W | Port A write data |
| a_fifo_q | input | W | Port A queue output word |
| a_dout | output | W | Port A read data |
| mbf1_a_n | output | 1 | Mailbox 1 full flag as seen by port A (writer), active low |
| mbf2_a_n | output | 1 | Mailbox 2 full flag as seen by port A (reader), active low |
| b_clk | input | 1 | Port B clock |
| b_sel | input | 1 | Port B select |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | W | Port B write data |
| b_fifo_q | input | W | Port B queue output word |
| b_dout | output | W | Port B read data |
| mbf1_b_n | output | 1 | Mailbox 1 full flag as seen by port B (reader), active low |
| mbf2_b_n | output | 1 | Mailbox 2 full flag as seen by port B (writer), active low |

## Verification
The properties assume that rst_n is released cleanly. They also assume that every control and data input changes away from its own clock's rising edge, so that each edge sees one settled operation. The stimulus meets this by driving every port input at the falling edge of that port's clock and returning it to idle after one rising edge. The two clocks run at unrelated periods, so the toggle crossings are met at varying phase offsets. Any check across domains waits a full SYNC+1 edges of the receiving clock before sampling.

// File: rtl/mbox_bridge.sv
module mbox_bridge #(
  parameter int W    = 36,
  parameter int SYNC = 2
) (
  input  logic         rst_n,
  input  logic         a_clk,
  input  logic         a_sel,
  input  logic         a_en,
  input  logic         a_wr,
  input  logic         a_mbx,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_fifo_q,
  output logic [W-1:0] a_dout,
  output logic         mbf1_a_n,
  output logic         mbf2_a_n,
  input  logic         b_clk,
  input  logic         b_sel,
  input  logic         b_en,
  input  logic         b_wr,
  input  logic         b_mbx,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_fifo_q,
  output logic [W-1:0] b_dout,
  output logic         mbf1_b_n,
  output logic         mbf2_b_n
);

  logic [W-1:0]    mail1_q, mail2_q;
  logic            set1_tg, clr1_tg, set2_tg, clr2_tg;
  logic [SYNC-1:0] clr1_s, set1_s, set2_s, clr2_s;

  wire full1_a = set1_tg ^ clr1_s[SYNC-1];
  wire full1_b = set1_s[SYNC-1] ^ clr1_tg;
  wire full2_b = set2_tg ^ clr2_s[SYNC-1];
  wire full2_a = set2_s[SYNC-1] ^ clr2_tg;

  wire a_go   = a_sel & a_en & a_mbx;
  wire b_go   = b_sel & b_en & b_mbx;
  wire put1   = a_go & a_wr & ~full1_a;
  wire take2  = a_go & ~a_wr & full2_a;
  wire put2   = b_go & b_wr & ~full2_b;
  wire take1  = b_go & ~b_wr & full1_b;

  always_ff @(posedge a_clk or negedge rst_n) begin
    if (!rst_n) begin
      mail1_q <= '0;
      set1_tg <= 1'b0;
      clr2_tg <= 1'b0;
      clr1_s  <= '0;
      set2_s  <= '0;
    end else begin
      if (put1) begin
        mail1_q <= a_din;
        set1_tg <= ~set1_tg;
      end
      if (take2) clr2_tg <= ~clr2_tg;
      clr1_s <= {clr1_s[SYNC-2:0], clr1_tg};
      set2_s <= {set2_s[SYNC-2:0], set2_tg};
    end
  end

  always_ff @(posedge b_clk or negedge rst_n) begin
    if (!rst_n) begin
      mail2_q <= '0;
      set2_tg <= 1'b0;
      clr1_tg <= 1'b0;
      set1_s  <= '0;
      clr2_s  <= '0;
    end else begin
      if (put2) begin
        mail2_q <= b_din;
        set2_tg <= ~set2_tg;
      end
      if (take1) clr1_tg <= ~clr1_tg;
      set1_s <= {set1_s[SYNC-2:0], set1_tg};
      clr2_s <= {clr2_s[SYNC-2:0], clr2_tg};
    end
  end

  assign a_dout   = a_mbx ? mail2_q : a_fifo_q;
  assign b_dout   = b_mbx ? mail1_q : b_fifo_q;
  assign mbf1_a_n = ~full1_a;
  assign mbf1_b_n = ~full1_b;
  assign mbf2_a_n = ~full2_a;
  assign mbf2_b_n = ~full2_b;

endmodule

module mbox_bridge_chk #(
  parameter int W = 36
) (
  input logic         rst_n,
  input logic         a_clk, a_sel, a_en, a_wr, a_mbx,
  input logic         b_clk, b_sel, b_en, b_wr, b_mbx,
  input logic         mbf1_a_n, mbf2_a_n, mbf1_b_n, mbf2_b_n,
  input logic [W-1:0] mail1_q, mail2_q
);

  p_wr_flag_low_r4: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_sel && a_en && a_wr && a_mbx && mbf1_a_n) |=> !mbf1_a_n);

  p_wr_flag_low_b_r4: assert property (@(posedge b_clk) disable iff (!rst_n)
    (b_sel && b_en && b_wr && b_mbx && mbf2_b_n) |=> !mbf2_b_n);

  p_mail1_hold_r5: assert property (@(posedge a_clk) disable iff (!rst_n)
    !(a_sel && a_en && a_wr && a_mbx && mbf1_a_n) |=> $stable(mail1_q));

  p_mail2_hold_r8: assert property (@(posedge b_clk) disable iff (!rst_n)
    !(b_sel && b_en && b_wr && b_mbx && mbf2_b_n) |=> $stable(mail2_q));

  p_rd_clear_r6: assert property (@(posedge b_clk) disable iff (!rst_n)
    (b_sel && b_en && !b_wr && b_mbx) |=> mbf1_b_n);

  p_rd_clear_a_r6: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_sel && a_en && !a_wr && a_mbx) |=> mbf2_a_n);

  p_order1_r10: assert property (@(posedge a_clk) disable iff (!rst_n)
    !mbf1_b_n |-> !mbf1_a_n);

  p_order2_r10: assert property (@(posedge b_clk) disable iff (!rst_n)
    !mbf2_a_n |-> !mbf2_b_n);

  always_comb begin
    if (!rst_n) begin
      p_reset_flags_r9: assert (mbf1_a_n && mbf2_a_n && mbf1_b_n && mbf2_b_n);
    end
  end

endmodule

bind mbox_bridge mbox_bridge_chk #(.W(W)) u_chk (
  .rst_n(rst_n),
  .a_clk(a_clk), .a_sel(a_sel), .a_en(a_en), .a_wr(a_wr), .a_mbx(a_mbx),
  .b_clk(b_clk), .b_sel(b_sel), .b_en(b_en), .b_wr(b_wr), .b_mbx(b_mbx),
  .mbf1_a_n(mbf1_a_n), .mbf2_a_n(mbf2_a_n),
  .mbf1_b_n(mbf1_b_n), .mbf2_b_n(mbf2_b_n),
  .mail1_q(mail1_q), .mail2_q(mail2_q)
);

// File: tb/mbox_bridge_bench.sv
module mbox_bridge_bench;
  localparam int W = 36;
  localparam int NV = 6;
  localparam logic [W-1:0] VEC [NV] = '{
    36'h0_0000_0001, 36'hF_FFFF_FFFF, 36'hA_5A5A_5A5A,
    36'h5_A5A5_A5A5, 36'h8_0000_0000, 36'h1_2345_6789
  };

  logic rst_n = 1'b0;
  logic a_clk = 1'b0, b_clk = 1'b0;
  logic a_sel = 0, a_en = 0, a_wr = 0, a_mbx = 0;
  logic b_sel = 0, b_en = 0, b_wr = 0, b_mbx = 0;
  logic [W-1:0] a_din = '0, b_din = '0, a_fifo_q = '0, b_fifo_q = '0;
  logic [W-1:0] a_dout, b_dout;
  logic mbf1_a_n, mbf2_a_n, mbf1_b_n, mbf2_b_n;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 a_clk = ~a_clk;
  always #3.5 b_clk = ~b_clk;

  mbox_bridge #(.W(W), .SYNC(2)) u_mbox_bridge (
    .rst_n(rst_n),
    .a_clk(a_clk), .a_sel(a_sel), .a_en(a_en), .a_wr(a_wr), .a_mbx(a_mbx),
    .a_din(a_din), .a_fifo_q(a_fifo_q), .a_dout(a_dout),
    .mbf1_a_n(mbf1_a_n), .mbf2_a_n(mbf2_a_n),
    .b_clk(b_clk), .b_sel(b_sel), .b_en(b_en), .b_wr(b_wr), .b_mbx(b_mbx),
    .b_din(b_din), .b_fifo_q(b_fifo_q), .b_dout(b_dout),
    .mbf1_b_n(mbf1_b_n), .mbf2_b_n(mbf2_b_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_op(input logic s, input logic e, input logic w, input logic m,
                      input logic [W-1:0] d);
    @(negedge a_clk);
    a_sel = s; a_en = e; a_wr = w; a_mbx = m; a_din = d;
    @(posedge a_clk);
    #1;
    a_sel = 0; a_en = 0; a_wr = 0; a_mbx = 0;
  endtask

  task automatic b_op(input logic s, input logic e, input logic w, input logic m,
                      input logic [W-1:0] d);
    @(negedge b_clk);
    b_sel = s; b_en = e; b_wr = w; b_mbx = m; b_din = d;
    @(posedge b_clk);
    #1;
    b_sel = 0; b_en = 0; b_wr = 0; b_mbx = 0;
  endtask

  task automatic wait_a(); repeat (3) @(posedge a_clk); #1; endtask
  task automatic wait_b(); repeat (3) @(posedge b_clk); #1; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R9: reset state
    a_mbx = 1; b_mbx = 1;
    #20;
    chk("R9 flags", {mbf1_a_n, mbf2_a_n, mbf1_b_n, mbf2_b_n}, 4'b1111);
    chk("R9 mail2", a_dout, '0);
    chk("R9 mail1", b_dout, '0);
    a_mbx = 0; b_mbx = 0;
    @(negedge a_clk); rst_n = 1;
    repeat (2) @(posedge b_clk);

    for (int i = 0; i < NV; i++) begin
      if (i % 2 == 0) begin
        a_op(1, 1, 1, 1, VEC[i]);
        chk("R4 writer flag 1", mbf1_a_n, 0);
        chk("R10 reader flag 1 not yet low", mbf1_b_n, 1);
        wait_b();
        chk("R4 reader flag 1", mbf1_b_n, 0);
        b_mbx = 1; #1;
        chk("R2 mail1 at b_dout", b_dout, VEC[i]);
        b_op(1, 1, 0, 1, '0);
        chk("R6 reader flag 1 high", mbf1_b_n, 1);
        b_mbx = 1; #1;
        chk("R8 mail1 kept", b_dout, VEC[i]);
        b_mbx = 0;
        wait_a();
        chk("R6 writer flag 1 high", mbf1_a_n, 1);
      end else begin
        b_op(1, 1, 1, 1, VEC[i]);
        chk("R4 writer flag 2", mbf2_b_n, 0);
        wait_a();
        chk("R4 reader flag 2", mbf2_a_n, 0);
        a_mbx = 1; #1;
        chk("R3 mail2 at a_dout", a_dout, VEC[i]);
        a_op(1, 1, 0, 1, '0);
        chk("R6 reader flag 2 high", mbf2_a_n, 1);
        a_mbx = 1; #1;
        chk("R8 mail2 kept", a_dout, VEC[i]);
        a_mbx = 0;
        wait_b();
        chk("R6 writer flag 2 high", mbf2_b_n, 1);
      end
    end

    // R5: lockout while full
    a_op(1, 1, 1, 1, 36'h0_DEAD_BEEF);
    a_op(1, 1, 1, 1, 36'h0_0BAD_F00D);
    wait_b();
    b_mbx = 1; #1;
    chk("R5 second write ignored", b_dout, 36'h0_DEAD_BEEF);
    b_mbx = 0;
    b_op(1, 1, 0, 1, '0);
    wait_a();
    chk("R6 flag 1 cleared after lockout", mbf1_a_n, 1);

    // R1: no operation without select or enable
    a_op(0, 1, 1, 1, 36'h3_3333_3333);
    chk("R1 no write without select", mbf1_a_n, 1);
    a_op(1, 0, 1, 1, 36'h4_4444_4444);
    chk("R1 no write without enable", mbf1_a_n, 1);
    wait_b();
    b_mbx = 1; #1;
    chk("R1 mail1 unchanged", b_dout, 36'h0_DEAD_BEEF);
    b_mbx = 0;

    // R6: reading an empty mailbox changes nothing
    b_op(1, 1, 0, 1, '0);
    chk("R6 empty read flag b", mbf1_b_n, 1);
    wait_a();
    chk("R6 empty read flag a", mbf1_a_n, 1);

    // R7: queue word path when mbx is 0
    a_fifo_q = 36'h7_0F0F_0F0F; b_fifo_q = 36'h6_F0F0_F0F0; #1;
    chk("R7 a_dout queue path", a_dout, 36'h7_0F0F_0F0F);
    chk("R7 b_dout queue path", b_dout, 36'h6_F0F0_F0F0);
    a_mbx = 1; #1;
    chk("R7 a_dout mailbox path", a_dout, VEC[NV-1]);
    a_mbx = 0;

    finish_run();
  end
endmodule